// File: doc/BRIEF.md
# Cartridge CHR Bank Latch with Write Conflicts

This block is the cartridge-side mapping logic for an 8-bit console whose program ROM sits in the upper 32 KiB of the CPU space. A small bank register picks which 8 KiB slice of the pattern ROM the video processor sees in its lowest 8 KiB. A CPU store anywhere from $8000 to $FFFF loads that register. The real board lets the ROM output and the CPU drive the data bus together during that store, so the value that lands in the latch can be the CPU byte ANDed with the ROM byte at the store address. A strap input turns this conflict model on or off. A second strap picks between a 2-bit bank field (four banks) and a 4-bit bank field (sixteen banks, 128 KiB).

The program window is unbanked. A third strap folds a 16 KiB ROM into both halves of the window. The nametable arrangement is fixed by a strap. An optional 2 KiB work RAM, present when the `WRAM_PRESENT` parameter is set, answers across $6000-$7FFF, with its contents repeating every 2 KiB. Latch bits 5 and 4 are brought out as plain outputs.

A two-state write controller accepts one store per strobe. The strobe is `cpu_we`, which may stay high for several cycles. In `ST_IDLE`, a high `cpu_we` takes the store: the register loads if bit 15 of the address is set, or the RAM is written if the address is in the RAM range. The controller then moves to `ST_HOLD` (transition IDLE_TO_HOLD). It stays in `ST_HOLD` while `cpu_we` remains high and returns to `ST_IDLE` when `cpu_we` drops (transition HOLD_TO_IDLE). Pattern-side addresses are formed combinationally from the current register value.

Top module: `chr_bank_mapper`

## Requirements
- R1: Reset (asynchronous, `rst_n` low) clears the bank register, so `chr_addr[16:13]` is 0 and `latch_hi` is 0.
- R2: With `cfg_conflict`=0 and `cfg_oversize`=0, a store with address bit 15 set loads the CPU byte unchanged. `chr_addr[14:13]` then equals data bits 1:0, and `chr_addr[16:15]` stays 0.
- R3: With `cfg_conflict`=1, the loaded value is the CPU byte ANDed with `prg_rdata`, the program ROM byte at the store address.
- R4: With `cfg_oversize`=1, `chr_addr[16:13]` equals bits 3:0 of the loaded value.
- R5: `latch_hi` equals bits 5:4 of the loaded value. These bits do not change `chr_addr` when `cfg_oversize`=0.
- R6: A store to an address below $8000 never changes the bank register.
- R7: A strobe held high over several cycles loads the register only once, in its first cycle. A data change while the strobe stays high has no effect.
- R8: `prg_addr` equals `cpu_addr[14:0]` when `cfg_prg16`=0. It equals `cpu_addr[14:0]` with bit 14 forced to 0 when `cfg_prg16`=1. `cpu_rdata` returns `prg_rdata` for addresses $8000-$FFFF.
- R9: `ciram_a10` equals `ppu_addr[10]` when `cfg_vmirror`=1 and `ppu_addr[11]` when `cfg_vmirror`=0.
- R10: With the RAM present, stores to $6000-$7FFF write the byte at `cpu_addr[10:0]`. Reads anywhere in $6000-$7FFF return the byte at `cpu_addr[10:0]`. Reads from $0000-$5FFF return $00.
- R11: `chr_sel` is 1 exactly when `ppu_addr` is below $2000. `chr_addr[12:0]` follows `ppu_addr[12:0]` in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU store data |
| cpu_we | input | 1 | CPU store strobe, may stay high for several cycles |
| cpu_rdata | output | 8 | CPU read data (program ROM, RAM or $00) |
| prg_addr | output | 15 | Program ROM address |
| prg_rdata | input | 8 | Program ROM byte at `prg_addr`, available in the same cycle |
| ppu_addr | input | 14 | Video processor address |
| chr_addr | output | 17 | Pattern ROM address |
| chr_sel | output | 1 | Pattern ROM select |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| latch_hi | output | 2 | Latch bits 5:4 |
| cfg_conflict | input | 1 | 1: AND the store data with the ROM byte |
| cfg_oversize | input | 1 | 1: 4-bit bank field, 0: 2-bit bank field |
| cfg_prg16 | input | 1 | 1: 16 KiB program ROM folded into both halves |
| cfg_vmirror | input | 1 | 1: vertical mirroring, 0: horizontal |

## Verification
The conflict case is the hardest to observe at the ports. The latched value depends on a ROM byte the CPU never reads, so a wrong AND would only show as a bank that disagrees with the data written. The bench's ROM returns the low byte of its address. Picking store addresses such as $80F1 and $A03C therefore sets a known mask, and that mask clears chosen bits of the written byte. Those bits show up both in the 4-bit oversize field and in `latch_hi`. The held-strobe case is reached by keeping `cpu_we` high across two edges while changing the data, then confirming that the first value stuck.

// File: rtl/cnm_pkg.sv
package cnm_pkg;

    // Store-acceptance controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } wr_state_e;

    // Upper three address bits that select the work RAM range
    localparam logic [2:0] WRAM_REGION = 3'b011;

endpackage

// File: rtl/cnm_wr_ctrl.sv
module cnm_wr_ctrl
    import cnm_pkg::*;
#(
    parameter int LATCH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_we,
    input  logic               cpu_a15,
    input  logic [LATCH_W-1:0] wdata,
    input  logic [LATCH_W-1:0] romdata,
    input  logic               cfg_conflict,
    output logic               wr_take,
    output logic               load_en,
    output logic [LATCH_W-1:0] bank_q
);

    wr_state_e          state_q;
    wr_state_e          state_d;
    logic [LATCH_W-1:0] eff_val;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        wr_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_we) begin
                    wr_take = 1'b1;
                    state_d = ST_HOLD;  // IDLE_TO_HOLD
                end
            end
            ST_HOLD: begin
                if (!cpu_we) begin
                    state_d = ST_IDLE;  // HOLD_TO_IDLE
                end
            end
        endcase
    end

    assign load_en = wr_take & cpu_a15;
    assign eff_val = cfg_conflict ? (wdata & romdata) : wdata;

    // Bank register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_en) begin
            bank_q <= eff_val;
        end
    end

endmodule

// File: rtl/cnm_addr_map.sv
module cnm_addr_map
    import cnm_pkg::*;
#(
    parameter int PRG_AW      = 15,
    parameter int CHR_BANK_W  = 4,
    parameter int NORM_BANK_W = 2,
    parameter int WIN_AW      = 13,
    localparam int CHR_AW     = WIN_AW + CHR_BANK_W,
    localparam int PAD_W      = CHR_BANK_W - NORM_BANK_W
) (
    input  logic [15:0]           cpu_addr,
    input  logic [WIN_AW:0]       ppu_addr,
    input  logic [CHR_BANK_W-1:0] bank_lo,
    input  logic                  cfg_oversize,
    input  logic                  cfg_prg16,
    input  logic                  cfg_vmirror,
    output logic [PRG_AW-1:0]     prg_addr,
    output logic [CHR_AW-1:0]     chr_addr,
    output logic                  chr_sel,
    output logic                  ciram_a10,
    output logic                  ram_hit
);

    always_comb begin
        prg_addr = cpu_addr[PRG_AW-1:0];
        if (cfg_prg16) begin
            prg_addr[PRG_AW-1] = 1'b0;
        end
    end

    always_comb begin
        if (cfg_oversize) begin
            chr_addr = {bank_lo, ppu_addr[WIN_AW-1:0]};
        end else begin
            chr_addr = {{PAD_W{1'b0}}, bank_lo[NORM_BANK_W-1:0], ppu_addr[WIN_AW-1:0]};
        end
    end

    assign chr_sel   = ~ppu_addr[WIN_AW];
    assign ciram_a10 = cfg_vmirror ? ppu_addr[10] : ppu_addr[11];
    assign ram_hit   = (cpu_addr[15:13] == WRAM_REGION);

endmodule

// File: rtl/cnm_wram.sv
module cnm_wram #(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import cnm_pkg::*;
#(
    parameter int PRG_AW       = 15,
    parameter int CHR_BANK_W   = 4,
    parameter int NORM_BANK_W  = 2,
    parameter int WIN_AW       = 13,
    parameter int LATCH_W      = 6,
    parameter int WRAM_AW      = 11,
    parameter bit WRAM_PRESENT = 1'b1,
    localparam int CHR_AW      = WIN_AW + CHR_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [7:0]        cpu_rdata,
    output logic [PRG_AW-1:0] prg_addr,
    input  logic [7:0]        prg_rdata,
    input  logic [WIN_AW:0]   ppu_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_sel,
    output logic              ciram_a10,
    output logic [1:0]        latch_hi,
    input  logic              cfg_conflict,
    input  logic              cfg_oversize,
    input  logic              cfg_prg16,
    input  logic              cfg_vmirror
);

    logic               wr_take;
    logic               load_en;
    logic [LATCH_W-1:0] bank_q;
    logic               ram_hit;
    logic [7:0]         ram_q;

    cnm_wr_ctrl #(
        .LATCH_W (LATCH_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_we       (cpu_we),
        .cpu_a15      (cpu_addr[15]),
        .wdata        (cpu_wdata[LATCH_W-1:0]),
        .romdata      (prg_rdata[LATCH_W-1:0]),
        .cfg_conflict (cfg_conflict),
        .wr_take      (wr_take),
        .load_en      (load_en),
        .bank_q       (bank_q)
    );

    cnm_addr_map #(
        .PRG_AW      (PRG_AW),
        .CHR_BANK_W  (CHR_BANK_W),
        .NORM_BANK_W (NORM_BANK_W),
        .WIN_AW      (WIN_AW)
    ) u_map (
        .cpu_addr     (cpu_addr),
        .ppu_addr     (ppu_addr),
        .bank_lo      (bank_q[CHR_BANK_W-1:0]),
        .cfg_oversize (cfg_oversize),
        .cfg_prg16    (cfg_prg16),
        .cfg_vmirror  (cfg_vmirror),
        .prg_addr     (prg_addr),
        .chr_addr     (chr_addr),
        .chr_sel      (chr_sel),
        .ciram_a10    (ciram_a10),
        .ram_hit      (ram_hit)
    );

    generate
        if (WRAM_PRESENT) begin : g_wram
            cnm_wram #(
                .AW (WRAM_AW),
                .DW (8)
            ) u_wram (
                .clk   (clk),
                .we    (wr_take & ram_hit),
                .addr  (cpu_addr[WRAM_AW-1:0]),
                .wdata (cpu_wdata),
                .rdata (ram_q)
            );
        end else begin : g_no_wram
            assign ram_q = 8'h00;
        end
    endgenerate

    always_comb begin
        if (cpu_addr[15]) begin
            cpu_rdata = prg_rdata;
        end else if (ram_hit && WRAM_PRESENT) begin
            cpu_rdata = ram_q;
        end else begin
            cpu_rdata = 8'h00;
        end
    end

    assign latch_hi = bank_q[LATCH_W-1:LATCH_W-2];

endmodule

// File: rtl/cnm_chk.sv
module cnm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_we,
    input logic       cpu_a15,
    input logic [7:0] cpu_wdata,
    input logic [7:0] prg_rdata,
    input logic       cfg_conflict,
    input logic       cfg_oversize,
    input logic       load_en,
    input logic [5:0] bank_q,
    input logic [1:0] chr_top
);

    p_low_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_a15) |=> $stable(bank_q));

    p_and_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && cfg_conflict) |=>
            ({2'b00, bank_q} == ($past(cpu_wdata) & $past(prg_rdata) & 8'h3F)));

    p_plain_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !cfg_conflict) |=> ({2'b00, bank_q} == ($past(cpu_wdata) & 8'h3F)));

    p_single_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);

    p_normal_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_oversize |-> (chr_top == 2'b00));

endmodule

bind chr_bank_mapper cnm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_we       (cpu_we),
    .cpu_a15      (cpu_addr[15]),
    .cpu_wdata    (cpu_wdata),
    .prg_rdata    (prg_rdata),
    .cfg_conflict (cfg_conflict),
    .cfg_oversize (cfg_oversize),
    .load_en      (load_en),
    .bank_q       (bank_q),
    .chr_top      (chr_addr[16:15])
);

// File: tb/tb_chr_bank_mapper.sv
`timescale 1ns/1ps
module tb_chr_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [14:0] prg_addr;
    logic [7:0]  prg_rdata;
    logic [13:0] ppu_addr = 14'h0000;
    logic [16:0] chr_addr;
    logic        chr_sel;
    logic        ciram_a10;
    logic [1:0]  latch_hi;
    logic        cfg_conflict = 1'b0;
    logic        cfg_oversize = 1'b0;
    logic        cfg_prg16 = 1'b0;
    logic        cfg_vmirror = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Program ROM model: each byte equals the low byte of its address
    assign prg_rdata = prg_addr[7:0];

    chr_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .prg_addr(prg_addr),
        .prg_rdata(prg_rdata), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
        .chr_sel(chr_sel), .ciram_a10(ciram_a10), .latch_hi(latch_hi),
        .cfg_conflict(cfg_conflict), .cfg_oversize(cfg_oversize),
        .cfg_prg16(cfg_prg16), .cfg_vmirror(cfg_vmirror)
    );

    // {conflict, oversize, addr, data, expected chr_addr[16:13], expected latch_hi}
    localparam logic [31:0] VEC [0:6] = '{
        {1'b0, 1'b0, 16'h8000, 8'h03, 4'h3, 2'd0},
        {1'b0, 1'b0, 16'hFFFF, 8'h37, 4'h3, 2'd3},
        {1'b0, 1'b1, 16'hC000, 8'h0A, 4'hA, 2'd0},
        {1'b1, 1'b0, 16'h80F1, 8'h23, 4'h1, 2'd2},
        {1'b1, 1'b1, 16'h9F0E, 8'hFF, 4'hE, 2'd0},
        {1'b1, 1'b1, 16'hA03C, 8'h35, 4'h4, 2'd3},
        {1'b0, 1'b0, 16'h8000, 8'h00, 4'h0, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bank at reset", {28'h0, chr_addr[16:13]}, 32'h0);
        chk("R1 latch_hi at reset", {30'h0, latch_hi}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: R2 / R3 / R4 / R5
        for (int i = 0; i < 7; i++) begin
            cfg_conflict = VEC[i][31];
            cfg_oversize = VEC[i][30];
            do_write(VEC[i][29:14], VEC[i][13:6]);
            ppu_addr = 14'h0000;
            #1;
            chk(VEC[i][31] ? "R3 conflict bank" : (VEC[i][30] ? "R4 oversize bank" : "R2 plain bank"),
                {28'h0, chr_addr[16:13]}, {28'h0, VEC[i][5:2]});
            chk("R5 latch_hi", {30'h0, latch_hi}, {30'h0, VEC[i][1:0]});
        end

        // R5: bits 5:4 set, normal mode, bank field stays 2 bits
        cfg_conflict = 1'b0;
        cfg_oversize = 1'b0;
        do_write(16'h8000, 8'h3E);
        chk("R5 normal ignores upper bits", {28'h0, chr_addr[16:13]}, 32'h2);
        chk("R5 latch_hi normal", {30'h0, latch_hi}, 32'h3);

        // R7: held strobe, data changes mid-strobe
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_wdata = 8'h01; cpu_we = 1'b1;
        @(negedge clk);
        cpu_wdata = 8'h02;
        @(negedge clk);
        cpu_we = 1'b0;
        @(negedge clk);
        chk("R7 single load per strobe", {28'h0, chr_addr[16:13]}, 32'h1);

        // R6: stores below $8000 leave the bank
        do_write(16'h8000, 8'h03);
        do_write(16'h7FFF, 8'hFF);
        chk("R6 store at 7FFF", {28'h0, chr_addr[16:13]}, 32'h3);
        do_write(16'h4000, 8'h00);
        chk("R6 store at 4000", {28'h0, chr_addr[16:13]}, 32'h3);
        chk("R6 latch_hi unchanged", {30'h0, latch_hi}, 32'h0);

        // R1: reset after a load
        do_write(16'h8000, 8'h3F);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset bank", {28'h0, chr_addr[16:13]}, 32'h0);
        chk("R1 mid-run reset latch_hi", {30'h0, latch_hi}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: program window
        cfg_prg16 = 1'b0;
        cpu_addr = 16'hC123;
        #1;
        chk("R8 prg_addr 32K", {17'h0, prg_addr}, 32'h4123);
        chk("R8 cpu_rdata from ROM", {24'h0, cpu_rdata}, 32'h23);
        cfg_prg16 = 1'b1;
        #1;
        chk("R8 prg_addr 16K", {17'h0, prg_addr}, 32'h0123);
        cfg_prg16 = 1'b0;

        // R9: mirroring
        cfg_vmirror = 1'b1;
        ppu_addr = 14'h0400; #1;
        chk("R9 vertical 0400", {31'h0, ciram_a10}, 32'h1);
        ppu_addr = 14'h0800; #1;
        chk("R9 vertical 0800", {31'h0, ciram_a10}, 32'h0);
        cfg_vmirror = 1'b0;
        #1;
        chk("R9 horizontal 0800", {31'h0, ciram_a10}, 32'h1);
        ppu_addr = 14'h0400; #1;
        chk("R9 horizontal 0400", {31'h0, ciram_a10}, 32'h0);

        // R10: work RAM and its repeat
        do_write(16'h6005, 8'hA5);
        cpu_addr = 16'h7805; #1;
        chk("R10 RAM repeat read", {24'h0, cpu_rdata}, 32'hA5);
        cpu_addr = 16'h6005; #1;
        chk("R10 RAM direct read", {24'h0, cpu_rdata}, 32'hA5);
        cpu_addr = 16'h4000; #1;
        chk("R10 low read zero", {24'h0, cpu_rdata}, 32'h0);
        chk("R6 RAM store keeps bank", {28'h0, chr_addr[16:13]}, 32'h0);

        // R11: pattern select and same-cycle window address
        do_write(16'h8000, 8'h02);
        ppu_addr = 14'h1FFF; #1;
        chk("R11 select below 2000", {31'h0, chr_sel}, 32'h1);
        chk("R11 window address", {15'h0, chr_addr}, 32'h05FFF);
        ppu_addr = 14'h2000; #1;
        chk("R11 select at 2000", {31'h0, chr_sel}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule